// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the array address stream for a synchronous burst read from a memory organised as 32-bit words. A host loads a 16-bit burst configuration through a two-write command sequence. It then starts a burst by presenting a start address together with a start strobe, and paces the burst with an advance input. The sequencer counts out the programmed first-data latency. After that it presents one array address per beat, together with a data-ready strobe that marks the beats that carry valid data.

All timing is measured in active edges of an external burst clock `bclk`. `bclk` is sampled by the system clock `clk`, and one configuration bit decides whether its rising or its falling transition counts. The configuration selects the following:
- a 4-beat, 8-beat or unbounded burst;
- wrapping sequential order or XOR-interleaved order inside the aligned window;
- a first-data latency of 2 to 9 active edges;
- one or two active edges between later beats;
- synchronous burst operation versus plain asynchronous reads, in which the sequencer stays idle.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `data_rdy` is 0 and `arr_addr` is 0. The configuration holds asynchronous mode, 4-beat sequential, latency code 0, single spacing and rising active edge.
- R2: The configuration loads only from a write whose code is 8'h60 followed by a write whose code is 8'h03. The value comes from `cmd_val` of the second write and is active from the next clock. Any other second code abandons the sequence. Field positions in `cmd_val`: bit 15 is synchronous enable, bits 14:12 are the latency code, bit 8 selects double spacing, bit 7 selects interleaved order, bit 6 selects the rising edge (0 selects falling), and bits 2:0 are the length (001 four, 010 eight, 111 continuous).
- R3: A confirmed value is rejected, leaving the previous configuration in force, when any of these holds: the length code is not one of the three listed, bits 11:9 or 5:3 are nonzero, or interleaved order is combined with continuous length.
- R4: While synchronous enable is 0, start strobes are ignored and `data_rdy` stays 0. Clearing it during a burst drops `data_rdy` within two clocks.
- R5: Only `bclk` transitions in the selected direction are active edges. `start` and `adv` are acted on only at active edges.
- R6: With latency L = code + 2, the first beat appears with `data_rdy` = 1 after the L-th advancing active edge that follows the start edge. `data_rdy` stays 0 before that.
- R7: With double spacing, each beat after the first is preceded by one advancing active edge with `data_rdy` = 0.
- R8: Sequential order on 4 or 8 beats: the beat-k offset is (start offset + k) modulo the window. The upper address bits are those of the start address.
- R9: Interleaved order: the beat-k offset is the start offset XOR k within the 4- or 8-word window.
- R10: Continuous order: beat k has address start + k, carrying into the upper bits with no wrap.
- R11: An active edge with `adv` = 0 and no start changes nothing: no latency progress, same address, same `data_rdy`.
- R12: A 4- or 8-beat burst ends at the advancing active edge after its last beat. `data_rdy` then returns to 0.
- R13: A start at an active edge during a burst restarts the burst from the new address, beginning again with the latency phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Burst clock, sampled on clk |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code of the write |
| cmd_val | input | 16 | Configuration value carried by the confirm write |
| start | input | 1 | Latch start address at the active edge |
| start_addr | input | ADDR_W | Burst start address |
| adv | input | 1 | Burst advance enable |
| arr_addr | output | ADDR_W | Current array address |
| data_rdy | output | 1 | Current beat carries valid data |

## Verification
Two functions can meet at one active edge: a new start can arrive in the same edge as a beat advance in the middle of a burst, and a configuration write can land while a burst is in its data phase. The bench provokes the first by raising `start` together with `adv` at an edge just after a delivered beat, and expects the restart to take priority: `data_rdy` drops and the full latency is counted again from the new address. It provokes the second by clearing synchronous enable in the data phase, and judges it by `data_rdy` falling within two clocks. Sweeps over length, order, spacing, latency and every start offset compare each beat with addresses computed arithmetically in the bench.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int CODE_W = 8;
    localparam int CFG_W  = 16;
    localparam int WIN_W  = 3;
    localparam int LAT_W  = 4;

    localparam logic [CODE_W-1:0] CODE_SETUP   = 8'h60;
    localparam logic [CODE_W-1:0] CODE_CONFIRM = 8'h03;

    localparam int F_SYNC   = 15;
    localparam int F_LAT_HI = 14;
    localparam int F_LAT_LO = 12;
    localparam int F_SLOW   = 8;
    localparam int F_ILV    = 7;
    localparam int F_RISE   = 6;

    localparam logic [2:0] LC_FOUR  = 3'b001;
    localparam logic [2:0] LC_EIGHT = 3'b010;
    localparam logic [2:0] LC_CONT  = 3'b111;

    localparam int LAT_BASE = 2;

    typedef enum logic [1:0] {
        BL_FOUR  = 2'd0,
        BL_EIGHT = 2'd1,
        BL_CONT  = 2'd2,
        BL_RSVD  = 2'd3
    } blen_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic       sync_en;
        logic [2:0] lat_code;
        logic       slow;
        logic       ilv;
        logic       rise;
        blen_e      blen;
    } bcfg_t;

    localparam bcfg_t CFG_RESET = '{
        sync_en:  1'b0,
        lat_code: 3'd0,
        slow:     1'b0,
        ilv:      1'b0,
        rise:     1'b1,
        blen:     BL_FOUR
    };

    function automatic logic cfg_legal(input logic [CFG_W-1:0] v);
        logic rsvd_clear;
        rsvd_clear = (v[11:9] == 3'b000) && (v[5:3] == 3'b000);
        case (v[2:0])
            LC_FOUR, LC_EIGHT: return rsvd_clear;
            LC_CONT:           return rsvd_clear && !v[F_ILV];
            default:           return 1'b0;
        endcase
    endfunction

    function automatic bcfg_t cfg_unpack(input logic [CFG_W-1:0] v);
        bcfg_t c;
        c.sync_en  = v[F_SYNC];
        c.lat_code = v[F_LAT_HI:F_LAT_LO];
        c.slow     = v[F_SLOW];
        c.ilv      = v[F_ILV];
        c.rise     = v[F_RISE];
        case (v[2:0])
            LC_FOUR:  c.blen = BL_FOUR;
            LC_EIGHT: c.blen = BL_EIGHT;
            LC_CONT:  c.blen = BL_CONT;
            default:  c.blen = BL_RSVD;
        endcase
        return c;
    endfunction

    function automatic logic [LAT_W-1:0] lat_edges(input logic [2:0] code);
        return {1'b0, code} + LAT_W'(LAT_BASE);
    endfunction

    function automatic logic [WIN_W-1:0] win_mask(input blen_e bl);
        return (bl == BL_FOUR) ? 3'b011 : 3'b111;
    endfunction

endpackage

// File: rtl/bseq_cfg_reg.sv
module bseq_cfg_reg
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [CFG_W-1:0]  cmd_val,
    output bcfg_t             cfg
);
    logic  armed;
    logic  val_ok;
    bcfg_t val_cfg;

    always_comb begin
        val_ok  = cfg_legal(cmd_val);
        val_cfg = cfg_unpack(cmd_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cfg   <= CFG_RESET;
        end else if (cmd_we) begin
            if (armed) begin
                armed <= 1'b0;
                if (cmd_code == CODE_CONFIRM && val_ok) begin
                    cfg <= val_cfg;
                end
            end else begin
                armed <= (cmd_code == CODE_SETUP);
            end
        end
    end
endmodule

// File: rtl/bseq_edge_sel.sv
module bseq_edge_sel (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic rise_sel,
    output logic act_ev
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bclk;
    end

    always_comb begin
        if (rise_sel) act_ev = bclk && !bclk_q;
        else          act_ev = !bclk && bclk_q;
    end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] beat,
    input  blen_e             blen,
    input  logic              ilv,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - WIN_W;

    logic [WIN_W-1:0]  mask;
    logic [WIN_W-1:0]  off;
    logic [ADDR_W-1:0] wmask;
    logic [ADDR_W-1:0] wrapped;

    always_comb begin
        mask    = win_mask(blen);
        off     = ilv ? (base[WIN_W-1:0] ^ beat[WIN_W-1:0])
                      : (base[WIN_W-1:0] + beat[WIN_W-1:0]);
        wmask   = {{HI_W{1'b0}}, mask};
        wrapped = (base & ~wmask) | ({{HI_W{1'b0}}, off} & wmask);
        addr    = (blen == BL_CONT) ? (base + beat) : wrapped;
    end
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_ev,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              adv,
    input  logic              sync_en,
    input  logic [2:0]        lat_code,
    input  logic              slow,
    input  blen_e             blen,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] beat,
    output logic              data_rdy
);
    phase_e           phase;
    logic [LAT_W-1:0] wait_cnt;
    logic             gap;
    logic             last_beat;

    always_comb begin
        case (blen)
            BL_FOUR:  last_beat = (beat[1:0] == 2'b11);
            BL_EIGHT: last_beat = (beat[2:0] == 3'b111);
            default:  last_beat = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            base     <= '0;
            beat     <= '0;
            wait_cnt <= '0;
            gap      <= 1'b0;
            data_rdy <= 1'b0;
        end else if (!sync_en) begin
            phase    <= PH_IDLE;
            data_rdy <= 1'b0;
            gap      <= 1'b0;
        end else if (act_ev) begin
            if (start) begin
                phase    <= PH_WAIT;
                base     <= start_addr;
                beat     <= '0;
                wait_cnt <= lat_edges(lat_code);
                gap      <= 1'b0;
                data_rdy <= 1'b0;
            end else if (adv) begin
                case (phase)
                    PH_WAIT: begin
                        if (wait_cnt == LAT_W'(1)) begin
                            phase    <= PH_DATA;
                            data_rdy <= 1'b1;
                            gap      <= 1'b0;
                        end else begin
                            wait_cnt <= wait_cnt - LAT_W'(1);
                        end
                    end
                    PH_DATA: begin
                        if (last_beat && !gap) begin
                            phase    <= PH_IDLE;
                            data_rdy <= 1'b0;
                        end else if (slow && !gap) begin
                            gap      <= 1'b1;
                            data_rdy <= 1'b0;
                        end else begin
                            beat     <= beat + ADDR_W'(1);
                            gap      <= 1'b0;
                            data_rdy <= 1'b1;
                        end
                    end
                    default: begin
                        data_rdy <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_code,
    input  logic [15:0]       cmd_val,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              adv,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              data_rdy
);
    bcfg_t             cfg_q;
    logic              act_ev;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] beat_q;

    bseq_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (cmd_we),
        .cmd_code (cmd_code),
        .cmd_val  (cmd_val),
        .cfg      (cfg_q)
    );

    bseq_edge_sel u_edge (
        .clk      (clk),
        .rst      (rst),
        .bclk     (bclk),
        .rise_sel (cfg_q.rise),
        .act_ev   (act_ev)
    );

    bseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .act_ev     (act_ev),
        .start      (start),
        .start_addr (start_addr),
        .adv        (adv),
        .sync_en    (cfg_q.sync_en),
        .lat_code   (cfg_q.lat_code),
        .slow       (cfg_q.slow),
        .blen       (cfg_q.blen),
        .base       (base_q),
        .beat       (beat_q),
        .data_rdy   (data_rdy)
    );

    bseq_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .base (base_q),
        .beat (beat_q),
        .blen (cfg_q.blen),
        .ilv  (cfg_q.ilv),
        .addr (arr_addr)
    );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              act_ev,
    input logic              adv,
    input logic              start,
    input logic              cmd_we,
    input bcfg_t             cfg,
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              data_rdy
);
    AST_QUIET_OFF_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!act_ev && !cmd_we && $stable(cfg)) |=> ($stable(arr_addr) && $stable(data_rdy))); // R5

    AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (rst)
        (act_ev && !adv && !start && !cmd_we && $stable(cfg)) |=> ($stable(arr_addr) && $stable(data_rdy))); // R11

    AST_ASYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cfg.sync_en |=> !data_rdy); // R4

    AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cfg.blen != BL_RSVD) && !(cfg.ilv && cfg.blen == BL_CONT)); // R3

    AST_STAY_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (data_rdy && cfg.blen != BL_CONT) |-> (arr_addr[ADDR_W-1:WIN_W] == base[ADDR_W-1:WIN_W])); // R8

    AST_RDY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(data_rdy) |-> $past(act_ev)); // R6
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .act_ev   (act_ev),
    .adv      (adv),
    .start    (start),
    .cmd_we   (cmd_we),
    .cfg      (cfg_q),
    .base     (base_q),
    .arr_addr (arr_addr),
    .data_rdy (data_rdy)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bclk = 1'b0;
    logic          cmd_we = 1'b0;
    logic [7:0]    cmd_code = '0;
    logic [15:0]   cmd_val = '0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          adv = 1'b0;
    logic [AW-1:0] arr_addr;
    logic          data_rdy;

    int   n_vec = 0;
    int   n_bad = 0;
    logic rise_cfg = 1'b1;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bclk(bclk), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .cmd_val(cmd_val), .start(start), .start_addr(start_addr), .adv(adv),
        .arr_addr(arr_addr), .data_rdy(data_rdy)
    );

    task automatic chk_a(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_r(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s data_rdy actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One bclk edge in the chosen direction, with start/adv presented there.
    task automatic step(input logic act_rise, input logic st, input logic ad);
        @(negedge clk); bclk = act_rise ? 1'b0 : 1'b1; start = 1'b0; adv = 1'b0;
        @(negedge clk); bclk = act_rise ? 1'b1 : 1'b0; start = st; adv = ad;
        @(negedge clk); start = 1'b0; adv = 1'b0;
    endtask

    task automatic ev_step(input logic st, input logic ad);
        step(rise_cfg, st, ad);
    endtask

    task automatic cmd_pair(input logic [7:0] c1, input logic [7:0] c2, input logic [15:0] v);
        @(negedge clk); cmd_we = 1'b1; cmd_code = c1; cmd_val = '0;
        @(negedge clk); cmd_code = c2; cmd_val = v;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    function automatic logic [15:0] mkcfg(input logic sy, input logic [2:0] lat, input logic sl,
                                          input logic il, input logic ri, input logic [2:0] lc);
        return {sy, lat, 3'b000, sl, il, ri, 3'b000, lc};
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int k,
                                               input int lenw, input logic il);
        int m, so, off;
        if (lenw == 0) return b + AW'(k);
        m   = lenw - 1;
        so  = int'(b[2:0]) & m;
        off = il ? (so ^ (k & m)) : ((so + k) & m);
        return (b & ~AW'(m)) | AW'(off);
    endfunction

    task automatic run_burst(input logic [AW-1:0] b, input int lenw, input logic il,
                             input logic sl, input int lat, input int nb, input string tag);
        string t;
        int    lcyc;
        t = (tag != "") ? tag : (lenw == 0) ? "R10" : (il ? "R9" : "R8");
        lcyc = lat + 2;
        start_addr = b;
        ev_step(1'b1, 1'b1);
        chk_r("R6 start edge", data_rdy, 1'b0);
        for (int i = 1; i < lcyc; i++) begin
            ev_step(1'b0, 1'b1);
            chk_r("R6 latency", data_rdy, 1'b0);
        end
        for (int k = 0; k < nb; k++) begin
            if (sl && k > 0) begin
                ev_step(1'b0, 1'b1);
                chk_r("R7 gap", data_rdy, 1'b0);
            end
            ev_step(1'b0, 1'b1);
            chk_r(t, data_rdy, 1'b1);
            chk_a(t, arr_addr, exp_addr(b, k, lenw, il));
        end
        if (lenw != 0) begin
            ev_step(1'b0, 1'b1);
            chk_r("R12 end", data_rdy, 1'b0);
        end
    endtask

    function automatic logic [2:0] lcode(input int lenw);
        return (lenw == 4) ? 3'b001 : (lenw == 8) ? 3'b010 : 3'b111;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_r("R1", data_rdy, 1'b0);
        chk_a("R1", arr_addr, '0);

        // R4 asynchronous default: starts ignored
        start_addr = 19'h12345;
        ev_step(1'b1, 1'b1);
        for (int i = 0; i < 12; i++) ev_step(1'b0, 1'b1);
        chk_r("R4 async", data_rdy, 1'b0);
        chk_a("R4 async", arr_addr, '0);

        // R2: valid 8-beat, then broken sequences that must not load
        cmd_pair(8'h60, 8'h03, mkcfg(1, 0, 0, 0, 1, 3'b010));
        rise_cfg = 1'b1;
        cmd_pair(8'h60, 8'h50, mkcfg(1, 0, 0, 0, 1, 3'b001));
        @(negedge clk); cmd_we = 1'b1; cmd_code = 8'h03; cmd_val = mkcfg(1, 0, 0, 0, 1, 3'b001);
        @(negedge clk); cmd_we = 1'b0;
        run_burst(19'h00A05, 8, 1'b0, 1'b0, 0, 8, "R2");

        // R3: rejected values keep a 4-beat sequential setup
        cmd_pair(8'h60, 8'h03, mkcfg(1, 1, 0, 0, 1, 3'b001));
        cmd_pair(8'h60, 8'h03, mkcfg(1, 0, 0, 1, 1, 3'b111));
        cmd_pair(8'h60, 8'h03, mkcfg(1, 0, 0, 0, 1, 3'b011));
        cmd_pair(8'h60, 8'h03, mkcfg(1, 0, 0, 0, 1, 3'b001) | 16'h0200);
        run_burst(19'h3F00E, 4, 1'b0, 1'b0, 1, 4, "R3");

        // R5: falling edge selected; rising transitions do nothing
        cmd_pair(8'h60, 8'h03, mkcfg(1, 0, 0, 0, 0, 3'b001));
        rise_cfg = 1'b0;
        start_addr = 19'h00101;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1);
        chk_r("R5 wrong edge", data_rdy, 1'b0);
        chk_a("R5 wrong edge", arr_addr, exp_addr(19'h3F00E, 3, 4, 1'b0));
        run_burst(19'h00101, 4, 1'b0, 1'b0, 0, 4, "R5");
        rise_cfg = 1'b1;

        // Sweep of fixed lengths, orders, offsets, spacing and latency
        for (int lw = 4; lw <= 8; lw += 4)
            for (int il = 0; il < 2; il++)
                for (int sl = 0; sl < 2; sl++)
                    for (int lt = 0; lt <= 7; lt += 7)
                        for (int so = 0; so < 8; so++) begin
                            cmd_pair(8'h60, 8'h03, mkcfg(1, 3'(lt), sl[0], il[0], 1, lcode(lw)));
                            run_burst(AW'((so + 8 * (lw * 31 + il * 7 + sl * 3 + lt + so * 11)) % (1 << AW)),
                                      lw, il[0], sl[0], lt, lw, "");
                        end

        // Continuous sequential: linear with carry
        for (int sl = 0; sl < 2; sl++)
            for (int so = 0; so < 8; so++) begin
                cmd_pair(8'h60, 8'h03, mkcfg(1, 3'(so % 3), sl[0], 0, 1, 3'b111));
                run_burst(AW'(19'h7FFF8 + so), 0, 1'b0, sl[0], so % 3, 12, "R10");
            end

        // R11: adv low holds latency and beats
        cmd_pair(8'h60, 8'h03, mkcfg(1, 0, 0, 0, 1, 3'b010));
        start_addr = 19'h04443;
        ev_step(1'b1, 1'b1);
        ev_step(1'b0, 1'b0);
        chk_r("R11 latency hold", data_rdy, 1'b0);
        ev_step(1'b0, 1'b1);
        chk_r("R11 latency hold", data_rdy, 1'b0);
        ev_step(1'b0, 1'b1);
        chk_r("R11", data_rdy, 1'b1);
        chk_a("R11", arr_addr, 19'h04443);
        ev_step(1'b0, 1'b0);
        chk_r("R11 beat hold", data_rdy, 1'b1);
        chk_a("R11 beat hold", arr_addr, 19'h04443);
        ev_step(1'b0, 1'b1);
        chk_a("R11 resume", arr_addr, 19'h04444);

        // R13: start coinciding with advance restarts the burst
        start_addr = 19'h10006;
        ev_step(1'b1, 1'b1);
        chk_r("R13 restart", data_rdy, 1'b0);
        ev_step(1'b0, 1'b1);
        chk_r("R13 restart latency", data_rdy, 1'b0);
        ev_step(1'b0, 1'b1);
        chk_r("R13", data_rdy, 1'b1);
        chk_a("R13", arr_addr, 19'h10006);
        ev_step(1'b0, 1'b1);
        chk_a("R13", arr_addr, 19'h10007);

        // R4: clearing synchronous enable mid-burst
        cmd_pair(8'h60, 8'h03, mkcfg(0, 0, 0, 0, 1, 3'b010));
        @(negedge clk);
        chk_r("R4 abort", data_rdy, 1'b0);
        start_addr = 19'h00010;
        for (int i = 0; i < 6; i++) ev_step(i == 0, 1'b1);
        chk_r("R4 async again", data_rdy, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule